// File: doc/BRIEF.md
# Endpoint FIFO RAM Controller

This block sits between the endpoint logic of a low-speed USB function and a single synchronous single-port byte RAM that holds every endpoint FIFO. Each requester names an endpoint, a direction and a 3-bit byte pointer. The block turns that into a RAM address, issues one registered RAM cycle with active-low enable and write-enable, and sends read data back to whichever side asked for it.

Two requesters share the RAM: the USB side and the CPU side. The USB side always wins a clash. A CPU request that loses is parked in a one-deep hold register and issued in the next cycle the USB side leaves free. While a request is parked, `cpu_wait` is high and any new CPU request is dropped.

Endpoint 0 owns one 8-byte region. Each of endpoints 1 and 2 may have an IN FIFO, an OUT FIFO or both. The counts are set by parameters, and a parameter can fold a matching IN/OUT pair onto one region. The address width is derived from the number of regions that result.

Top module: `fifo_ram_ctrl`

## Requirements
- R1: The RAM address is region*8 + pointer. Regions are numbered with endpoint 0 first, then endpoints 1 and 2 in ascending order, IN before OUT. With N_IN=2, N_OUT=2 and sharing off, the regions are: ep0 = 0, ep1 IN = 1, ep1 OUT = 2, ep2 IN = 3, ep2 OUT = 4 (address width 6).
- R2: Endpoint 0 has a single region. Its direction input (`*_in`, 1 = IN) has no effect on the address.
- R3: With SHARED=1, IN k and OUT k map to the same region whenever both exist. With N_IN=2, N_OUT=1 and SHARED=1, the regions are ep0 = 0, ep1 IN/OUT = 1, ep2 IN = 2 (address width 5).
- R4: A request naming an endpoint/direction that is not configured (endpoint 3, or k greater than N_IN or N_OUT) starts no RAM cycle.
- R5: A request sampled at clock edge k drives `ram_nce` low for exactly the cycle after edge k. `ram_nwr` is low in that cycle only for writes (`*_we` = 1). Both are high when idle.
- R6: When both sides present valid requests at the same edge, the USB request is issued and `cpu_wait` goes high. The held CPU request is issued at the next edge with no valid USB request, and `cpu_wait` falls at that edge.
- R7: A CPU request presented while `cpu_wait` is high is ignored.
- R8: For a read issued at edge k, the requesting side's `*_rvalid` is high for one cycle after edge k+2, carrying the byte at that address. The other side's `*_rvalid` stays low.
- R9: Synchronous active-high reset drives `ram_nce`/`ram_nwr` high and both `*_rvalid` and `cpu_wait` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usb_req | input | 1 | USB-side access request |
| usb_ep | input | 2 | USB-side endpoint number |
| usb_in | input | 1 | USB-side direction, 1 = IN |
| usb_ptr | input | 3 | USB-side FIFO byte pointer |
| usb_we | input | 1 | USB-side write, 0 = read |
| usb_wdata | input | 8 | USB-side write byte |
| usb_rdata | output | 8 | Read byte returned to USB side |
| usb_rvalid | output | 1 | USB-side read byte valid |
| cpu_req | input | 1 | CPU-side access request |
| cpu_ep | input | 2 | CPU-side endpoint number |
| cpu_in | input | 1 | CPU-side direction, 1 = IN |
| cpu_ptr | input | 3 | CPU-side FIFO byte pointer |
| cpu_we | input | 1 | CPU-side write, 0 = read |
| cpu_wdata | input | 8 | CPU-side write byte |
| cpu_rdata | output | 8 | Read byte returned to CPU side |
| cpu_rvalid | output | 1 | CPU-side read byte valid |
| cpu_wait | output | 1 | A CPU request is held after losing arbitration |
| ram_nce | output | 1 | RAM enable, active low |
| ram_nwr | output | 1 | RAM write enable, active low |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | Byte to RAM |
| ram_rdata | input | 8 | Byte from RAM |

## Verification
The bench writes a distinct byte into every region from one side and reads it back from the other. A wrong region order or a shifted pointer therefore shows up as a wrong address or as a byte coming from the wrong FIFO. A same-edge clash checks that the USB access goes first and the CPU access follows one cycle later. A design that dropped or reordered the held request would show the wrong address or lose the CPU read data. A second CPU request sent during the wait, a request to endpoint 3, and a request to an OUT endpoint left out of the shared configuration must each leave the RAM enable high. A design that accepted them would start a spurious cycle. Reading an OUT pointer in the shared instance returns the byte written through IN, which catches a design that kept the pair apart.

// File: rtl/fifo_ram_pkg.sv
package fifo_ram_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 3;
  localparam int EP_W   = 2;
  localparam int MAX_EP = 2;
  localparam int LUT_N  = 2 ** (EP_W + 1);

  typedef enum logic [1:0] {SRC_NONE, SRC_USB, SRC_HELD, SRC_CPU} src_e;

  // Region index for an endpoint/direction, or -1 when not configured.
  function automatic int region_of(int ep, int is_in, int n_in, int n_out, int shared);
    int  base;
    int  result;
    bit  has_in;
    bit  has_out;
    base   = 1;
    result = (ep == 0) ? 0 : -1;
    for (int k = 1; k <= MAX_EP; k++) begin
      has_in  = (k <= n_in);
      has_out = (k <= n_out);
      if (k == ep) begin
        if (is_in != 0) result = has_in ? base : -1;
        else if (has_out) result = (shared != 0 && has_in) ? base : base + (has_in ? 1 : 0);
      end
      base = base + (has_in ? 1 : 0) + (has_out ? 1 : 0)
                  - ((shared != 0 && has_in && has_out) ? 1 : 0);
    end
    return result;
  endfunction

  function automatic int region_count(int n_in, int n_out, int shared);
    int  base;
    bit  has_in;
    bit  has_out;
    base = 1;
    for (int k = 1; k <= MAX_EP; k++) begin
      has_in  = (k <= n_in);
      has_out = (k <= n_out);
      base = base + (has_in ? 1 : 0) + (has_out ? 1 : 0)
                  - ((shared != 0 && has_in && has_out) ? 1 : 0);
    end
    return base;
  endfunction
endpackage

// File: rtl/fifo_addr_map.sv
module fifo_addr_map import fifo_ram_pkg::*; #(
  parameter  int N_IN   = 2,
  parameter  int N_OUT  = 2,
  parameter  int SHARED = 0,
  localparam int RW     = $clog2(region_count(N_IN, N_OUT, SHARED)),
  localparam int AW     = RW + PTR_W
) (
  input  logic [EP_W-1:0]  ep,
  input  logic             is_in,
  input  logic [PTR_W-1:0] ptr,
  output logic [AW-1:0]    addr,
  output logic             hit
);
  logic [RW-1:0]    base_lut [LUT_N];
  logic [LUT_N-1:0] hit_lut;

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    localparam int R = region_of(i / 2, i % 2, N_IN, N_OUT, SHARED);
    assign base_lut[i] = RW'((R < 0) ? 0 : R);
    assign hit_lut[i]  = (R >= 0);
  end

  logic [EP_W:0] sel;
  assign sel  = {ep, is_in};
  assign addr = {base_lut[sel], ptr};
  assign hit  = hit_lut[sel];
endmodule

// File: rtl/fifo_ram_arb.sv
module fifo_ram_arb import fifo_ram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usb_go,
  input  logic [AW-1:0]     usb_addr,
  input  logic              usb_we,
  input  logic [DATA_W-1:0] usb_wdata,
  input  logic              cpu_go,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              ram_nce,
  output logic              ram_nwr,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              cpu_wait,
  output logic              tag_rd,
  output logic              tag_cpu
);
  logic [AW-1:0]     held_addr;
  logic              held_we;
  logic [DATA_W-1:0] held_wdata;
  logic              cpu_fresh;
  src_e              src;
  logic [AW-1:0]     sel_addr;
  logic              sel_we;
  logic [DATA_W-1:0] sel_wdata;

  assign cpu_fresh = cpu_go && !cpu_wait;

  always_comb begin
    if (usb_go)         src = SRC_USB;
    else if (cpu_wait)  src = SRC_HELD;
    else if (cpu_fresh) src = SRC_CPU;
    else                src = SRC_NONE;
    case (src)
      SRC_USB:  begin sel_addr = usb_addr;  sel_we = usb_we;  sel_wdata = usb_wdata;  end
      SRC_HELD: begin sel_addr = held_addr; sel_we = held_we; sel_wdata = held_wdata; end
      SRC_CPU:  begin sel_addr = cpu_addr;  sel_we = cpu_we;  sel_wdata = cpu_wdata;  end
      default:  begin sel_addr = '0;        sel_we = 1'b0;    sel_wdata = '0;         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_nce    <= 1'b1;
      ram_nwr    <= 1'b1;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      tag_rd     <= 1'b0;
      tag_cpu    <= 1'b0;
      cpu_wait   <= 1'b0;
      held_addr  <= '0;
      held_we    <= 1'b0;
      held_wdata <= '0;
    end else begin
      ram_nce   <= (src == SRC_NONE);
      ram_nwr   <= !((src != SRC_NONE) && sel_we);
      ram_addr  <= sel_addr;
      ram_wdata <= sel_wdata;
      tag_rd    <= (src != SRC_NONE) && !sel_we;
      tag_cpu   <= (src == SRC_HELD) || (src == SRC_CPU);
      if (usb_go && cpu_fresh) begin
        cpu_wait   <= 1'b1;
        held_addr  <= cpu_addr;
        held_we    <= cpu_we;
        held_wdata <= cpu_wdata;
      end else if (src == SRC_HELD) begin
        cpu_wait <= 1'b0;
      end
    end
  end

  p_usb_first_r6: assert property (@(posedge clk) disable iff (rst)
    usb_go |=> (!ram_nce && ram_addr == $past(usb_addr)));
  p_clash_parks_r6: assert property (@(posedge clk) disable iff (rst)
    (usb_go && cpu_go && !cpu_wait) |=> cpu_wait);
  p_held_served_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wait && !usb_go) |=> (!cpu_wait && !ram_nce && ram_addr == $past(held_addr)));
  p_idle_no_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    (!usb_go && !cpu_wait && !cpu_go) |=> ram_nce);
  p_write_in_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    !ram_nwr |-> !ram_nce);
endmodule

// File: rtl/fifo_rd_return.sv
module fifo_rd_return import fifo_ram_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_rd,
  input  logic              tag_cpu,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] usb_rdata,
  output logic              usb_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid
);
  logic stg_rd;
  logic stg_cpu;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_rd     <= 1'b0;
      stg_cpu    <= 1'b0;
      usb_rvalid <= 1'b0;
      cpu_rvalid <= 1'b0;
      usb_rdata  <= '0;
      cpu_rdata  <= '0;
    end else begin
      stg_rd     <= tag_rd;
      stg_cpu    <= tag_cpu;
      usb_rvalid <= stg_rd && !stg_cpu;
      cpu_rvalid <= stg_rd && stg_cpu;
      if (stg_rd && !stg_cpu) usb_rdata <= ram_rdata;
      if (stg_rd && stg_cpu)  cpu_rdata <= ram_rdata;
    end
  end
endmodule

// File: rtl/fifo_ram_ctrl.sv
module fifo_ram_ctrl import fifo_ram_pkg::*; #(
  parameter  int N_IN   = 2,
  parameter  int N_OUT  = 2,
  parameter  int SHARED = 0,
  localparam int RAM_AW = $clog2(region_count(N_IN, N_OUT, SHARED)) + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usb_req,
  input  logic [EP_W-1:0]   usb_ep,
  input  logic              usb_in,
  input  logic [PTR_W-1:0]  usb_ptr,
  input  logic              usb_we,
  input  logic [DATA_W-1:0] usb_wdata,
  output logic [DATA_W-1:0] usb_rdata,
  output logic              usb_rvalid,
  input  logic              cpu_req,
  input  logic [EP_W-1:0]   cpu_ep,
  input  logic              cpu_in,
  input  logic [PTR_W-1:0]  cpu_ptr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              cpu_wait,
  output logic              ram_nce,
  output logic              ram_nwr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic [RAM_AW-1:0] usb_addr;
  logic [RAM_AW-1:0] cpu_addr;
  logic              usb_hit;
  logic              cpu_hit;
  logic              tag_rd;
  logic              tag_cpu;

  fifo_addr_map #(.N_IN(N_IN), .N_OUT(N_OUT), .SHARED(SHARED)) u_map_usb (
    .ep(usb_ep), .is_in(usb_in), .ptr(usb_ptr), .addr(usb_addr), .hit(usb_hit));

  fifo_addr_map #(.N_IN(N_IN), .N_OUT(N_OUT), .SHARED(SHARED)) u_map_cpu (
    .ep(cpu_ep), .is_in(cpu_in), .ptr(cpu_ptr), .addr(cpu_addr), .hit(cpu_hit));

  fifo_ram_arb #(.AW(RAM_AW)) u_arb (
    .clk(clk), .rst(rst),
    .usb_go(usb_req && usb_hit), .usb_addr(usb_addr), .usb_we(usb_we), .usb_wdata(usb_wdata),
    .cpu_go(cpu_req && cpu_hit), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .ram_nce(ram_nce), .ram_nwr(ram_nwr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cpu_wait(cpu_wait), .tag_rd(tag_rd), .tag_cpu(tag_cpu));

  fifo_rd_return u_ret (
    .clk(clk), .rst(rst), .tag_rd(tag_rd), .tag_cpu(tag_cpu), .ram_rdata(ram_rdata),
    .usb_rdata(usb_rdata), .usb_rvalid(usb_rvalid),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid));

  p_return_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    (usb_rvalid || cpu_rvalid) |-> $past(!ram_nce && ram_nwr, 2));
  p_single_return_r8: assert property (@(posedge clk) disable iff (rst)
    !(usb_rvalid && cpu_rvalid));
  p_reset_idle_r9: assert property (@(posedge clk)
    $past(rst) |-> (ram_nce && ram_nwr && !cpu_wait && !usb_rvalid && !cpu_rvalid));
endmodule

// File: tb/sim_fifo_ram_ctrl.sv
module sim_fifo_ram_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       usb_req = 0, usb_in = 0, usb_we = 0;
  logic [1:0] usb_ep = 0;
  logic [2:0] usb_ptr = 0;
  logic [7:0] usb_wdata = 0;
  logic       cpu_req = 0, cpu_in = 0, cpu_we = 0;
  logic [1:0] cpu_ep = 0;
  logic [2:0] cpu_ptr = 0;
  logic [7:0] cpu_wdata = 0;

  logic [7:0] u0_urd, u0_crd, u0_wd, u0_rd;
  logic       u0_urv, u0_crv, u0_wait, u0_nce, u0_nwr;
  logic [5:0] u0_addr;
  logic [7:0] u1_urd, u1_crd, u1_wd, u1_rd;
  logic       u1_urv, u1_crv, u1_wait, u1_nce, u1_nwr;
  logic [4:0] u1_addr;

  fifo_ram_ctrl u0 (
    .clk(clk), .rst(rst),
    .usb_req(usb_req), .usb_ep(usb_ep), .usb_in(usb_in), .usb_ptr(usb_ptr), .usb_we(usb_we),
    .usb_wdata(usb_wdata), .usb_rdata(u0_urd), .usb_rvalid(u0_urv),
    .cpu_req(cpu_req), .cpu_ep(cpu_ep), .cpu_in(cpu_in), .cpu_ptr(cpu_ptr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(u0_crd), .cpu_rvalid(u0_crv), .cpu_wait(u0_wait),
    .ram_nce(u0_nce), .ram_nwr(u0_nwr), .ram_addr(u0_addr), .ram_wdata(u0_wd), .ram_rdata(u0_rd));

  fifo_ram_ctrl #(.N_IN(2), .N_OUT(1), .SHARED(1)) u1 (
    .clk(clk), .rst(rst),
    .usb_req(usb_req), .usb_ep(usb_ep), .usb_in(usb_in), .usb_ptr(usb_ptr), .usb_we(usb_we),
    .usb_wdata(usb_wdata), .usb_rdata(u1_urd), .usb_rvalid(u1_urv),
    .cpu_req(cpu_req), .cpu_ep(cpu_ep), .cpu_in(cpu_in), .cpu_ptr(cpu_ptr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(u1_crd), .cpu_rvalid(u1_crv), .cpu_wait(u1_wait),
    .ram_nce(u1_nce), .ram_nwr(u1_nwr), .ram_addr(u1_addr), .ram_wdata(u1_wd), .ram_rdata(u1_rd));

  logic [7:0] mem0 [64];
  logic [7:0] mem1 [32];
  always_ff @(posedge clk) begin
    if (!u0_nce) begin
      if (!u0_nwr) mem0[u0_addr] <= u0_wd;
      else         u0_rd <= mem0[u0_addr];
    end
    if (!u1_nce) begin
      if (!u1_nwr) mem1[u1_addr] <= u1_wd;
      else         u1_rd <= mem1[u1_addr];
    end
  end

  typedef struct packed {
    logic       cpu;
    logic [1:0] ep;
    logic       dir_in;
    logic [2:0] ptr;
    logic       we;
    logic [7:0] data;
    logic [5:0] addr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 2'd0, 1'b0, 3'd3, 1'b1, 8'hA5, 6'd3},
    '{1'b1, 2'd1, 1'b1, 3'd0, 1'b1, 8'h11, 6'd8},
    '{1'b0, 2'd1, 1'b0, 3'd7, 1'b1, 8'h22, 6'd23},
    '{1'b1, 2'd2, 1'b1, 3'd5, 1'b1, 8'h33, 6'd29},
    '{1'b0, 2'd2, 1'b0, 3'd2, 1'b1, 8'h44, 6'd34},
    '{1'b1, 2'd0, 1'b1, 3'd3, 1'b0, 8'hA5, 6'd3},
    '{1'b0, 2'd1, 1'b1, 3'd0, 1'b0, 8'h11, 6'd8},
    '{1'b1, 2'd1, 1'b0, 3'd7, 1'b0, 8'h22, 6'd23},
    '{1'b0, 2'd2, 1'b1, 3'd5, 1'b0, 8'h33, 6'd29},
    '{1'b1, 2'd2, 1'b0, 3'd2, 1'b0, 8'h44, 6'd34}
  };

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cpu, input logic [1:0] ep, input logic din,
                       input logic [2:0] ptr, input logic we, input logic [7:0] d);
    if (cpu) begin
      cpu_req = 1; cpu_ep = ep; cpu_in = din; cpu_ptr = ptr; cpu_we = we; cpu_wdata = d;
    end else begin
      usb_req = 1; usb_ep = ep; usb_in = din; usb_ptr = ptr; usb_we = we; usb_wdata = d;
    end
  endtask

  task automatic idle_all();
    usb_req = 0;
    cpu_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(u0_nce === 1'b1 && u0_nwr === 1'b1, "R9", {u0_nce, u0_nwr}, 2'b11);
    chk(u0_wait === 1'b0 && u0_urv === 1'b0 && u0_crv === 1'b0, "R9",
        {u0_wait, u0_urv, u0_crv}, 0);
    rst = 0;
    @(negedge clk);
    chk(u0_nce === 1'b1, "R5", u0_nce, 1);

    // Table walk: writes from one side, reads back from the other
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.cpu, v.ep, v.dir_in, v.ptr, v.we, v.data);
      @(negedge clk);
      idle_all();
      chk(u0_nce === 1'b0, "R5", u0_nce, 0);
      chk(u0_addr === v.addr, (v.ep == 0) ? "R2" : "R1", u0_addr, v.addr);
      chk(u0_nwr === !v.we, "R5", u0_nwr, !v.we);
      @(negedge clk);
      chk(u0_nce === 1'b1, "R5", u0_nce, 1);
      @(negedge clk);
      if (!v.we) begin
        if (v.cpu) begin
          chk(u0_crv === 1'b1 && u0_crd === v.data, "R8", u0_crd, v.data);
          chk(u0_urv === 1'b0, "R8", u0_urv, 0);
        end else begin
          chk(u0_urv === 1'b1 && u0_urd === v.data, "R8", u0_urd, v.data);
          chk(u0_crv === 1'b0, "R8", u0_crv, 0);
        end
      end
      @(negedge clk);
      chk(u0_urv === 1'b0 && u0_crv === 1'b0, "R8", {u0_urv, u0_crv}, 0);
    end

    // R6/R7: clash, then a second CPU request while parked
    drive(1'b0, 2'd1, 1'b1, 3'd1, 1'b1, 8'h55);
    drive(1'b1, 2'd0, 1'b0, 3'd3, 1'b0, 8'h00);
    @(negedge clk);
    chk(u0_nce === 1'b0 && u0_addr === 6'd9 && u0_nwr === 1'b0, "R6", u0_addr, 9);
    chk(u0_wait === 1'b1, "R6", u0_wait, 1);
    usb_req = 0;
    drive(1'b1, 2'd1, 1'b0, 3'd7, 1'b0, 8'h00);
    @(negedge clk);
    cpu_req = 0;
    chk(u0_nce === 1'b0 && u0_addr === 6'd3 && u0_nwr === 1'b1, "R6", u0_addr, 3);
    chk(u0_wait === 1'b0, "R6", u0_wait, 0);
    @(negedge clk);
    chk(u0_nce === 1'b1, "R7", u0_nce, 1);
    @(negedge clk);
    chk(u0_crv === 1'b1 && u0_crd === 8'hA5, "R6", u0_crd, 8'hA5);
    @(negedge clk);
    chk(u0_nce === 1'b1 && u0_crv === 1'b0, "R7", {u0_nce, u0_crv}, 2'b10);

    // R4: endpoint 3 on u0, ep2 OUT on the shared instance
    drive(1'b0, 2'd3, 1'b0, 3'd0, 1'b1, 8'h77);
    @(negedge clk);
    idle_all();
    chk(u0_nce === 1'b1, "R4", u0_nce, 1);
    @(negedge clk);
    drive(1'b0, 2'd2, 1'b0, 3'd2, 1'b0, 8'h00);
    @(negedge clk);
    idle_all();
    chk(u1_nce === 1'b1, "R4", u1_nce, 1);
    chk(u0_nce === 1'b0 && u0_addr === 6'd34, "R1", u0_addr, 34);
    repeat (3) @(negedge clk);

    // R3: shared instance, OUT read sees byte written through IN
    drive(1'b1, 2'd1, 1'b0, 3'd0, 1'b0, 8'h00);
    @(negedge clk);
    idle_all();
    chk(u1_nce === 1'b0 && u1_addr === 5'd8, "R3", u1_addr, 8);
    @(negedge clk);
    @(negedge clk);
    chk(u1_crv === 1'b1 && u1_crd === 8'h11, "R3", u1_crd, 8'h11);
    drive(1'b0, 2'd2, 1'b1, 3'd5, 1'b0, 8'h00);
    @(negedge clk);
    idle_all();
    chk(u1_nce === 1'b0 && u1_addr === 5'd21, "R3", u1_addr, 21);
    repeat (3) @(negedge clk);

    // R9: reset in the middle of a clash
    drive(1'b0, 2'd1, 1'b1, 3'd2, 1'b0, 8'h00);
    drive(1'b1, 2'd1, 1'b0, 3'd2, 1'b0, 8'h00);
    @(negedge clk);
    idle_all();
    rst = 1;
    @(negedge clk);
    chk(u0_nce === 1'b1 && u0_wait === 1'b0 && u0_urv === 1'b0, "R9",
        {u0_nce, u0_wait, u0_urv}, 3'b100);
    rst = 0;
    @(negedge clk);
    chk(u0_nce === 1'b1, "R9", u0_nce, 1);

    finish_run();
  end
endmodule